// File: doc/BRIEF.md
# Four-Register Configurable Pipeline Register

This block holds four data registers (A1, A2, B1, B2) behind a single data input and a single data output. Each rising clock edge it performs one of four actions picked by a 2-bit operation code: hold everything, load the first stage of pipeline A, load the first stage of pipeline B, or shift data through all four registers as one 4-deep chain. Used this way, the four registers work either as two independent 2-deep pipelines or as one 4-deep pipeline.

A compile-time parameter sets how a first-stage load treats the second stage. In push-down mode the old first-stage value moves into the second stage on the same edge. In overwrite mode the first stage is replaced in place, and the second stage can then change only through the shift.

A 2-bit select routes any one register to the output. The output stage is modelled as a data bus plus a drive-enable flag. While the active-low output enable is high, the bus reads zero and the flag is low, but the registers keep updating.

Top module: `qsp_pipe4`

## Requirements
- R1: A synchronous active-high reset clears all four registers to zero on the next rising edge.
- R2: Operation code 3 (hold) leaves all four registers unchanged.
- R3: Operation code 0 (shift) moves data in one edge along the chain input -> A1 -> A2 -> B1 -> B2, and the old B2 value is lost.
- R4: Operation code 2 writes the input into A1 and leaves B1 and B2 unchanged.
- R5: Operation code 1 writes the input into B1 and leaves A1 and A2 unchanged.
- R6: With PUSH_DOWN=1, operation code 2 also copies the old A1 into A2, and operation code 1 also copies the old B1 into B2, on the same edge.
- R7: With PUSH_DOWN=0, operation codes 1 and 2 leave A2 and B2 unchanged.
- R8: The output select picks a register combinationally, with the encoding 0=B2, 1=B1, 2=A2, 3=A1.
- R9: While oe_n is 1, dout reads all zeros and dout_en is 0, and the registers still update as the operation code directs.
- R10: While oe_n is 0, dout_en is 1 and dout carries the selected register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 2 | Operation code: 0 shift, 1 load B1, 2 load A1, 3 hold |
| din_i | input | DATA_W | Data input |
| sel_i | input | 2 | Output select: 0 B2, 1 B1, 2 A2, 3 A1 |
| oe_n_i | input | 1 | Output enable, active low |
| dout_o | output | DATA_W | Selected register, or zero when disabled |
| dout_en_o | output | 1 | High while the output is driven |

## Verification
The bench builds two copies of the block side by side, one with PUSH_DOWN=1 and one with PUSH_DOWN=0, both at DATA_W=8, and drives the same stimulus into both. With both copies running, each first-stage load shows the push-down and overwrite behaviours against each other in the same cycle. It also shows whether a shift refills the second stage correctly after earlier overwrites. The bench reads every register back through the output select after every operation, so each shift, load, hold and disabled-output cycle is checked in all four registers of both copies.

// File: rtl/qsp_pkg.sv
`timescale 1ns/1ps
package qsp_pkg;

  localparam int unsigned SLOTS = 4;
  localparam int unsigned SEL_W = $clog2(SLOTS);

  typedef enum logic [1:0] {
    OP_SHIFT  = 2'd0,
    OP_LOAD_B = 2'd1,
    OP_LOAD_A = 2'd2,
    OP_HOLD   = 2'd3
  } qsp_op_e;

  // internal slot numbering follows the shift chain
  typedef enum logic [1:0] {
    SL_A1 = 2'd0,
    SL_A2 = 2'd1,
    SL_B1 = 2'd2,
    SL_B2 = 2'd3
  } qsp_slot_e;

  typedef struct packed {
    logic [SLOTS-1:0] we;        // slot written this edge
    logic [SLOTS-1:0] take_din;  // slot fed from input, else from its chain predecessor
  } qsp_ctl_t;

  // external select counts from the tail of the chain
  function automatic logic [SEL_W-1:0] sel_to_slot(logic [SEL_W-1:0] sel);
    return SEL_W'(SLOTS - 1) - sel;
  endfunction

  function automatic qsp_ctl_t decode_op(qsp_op_e op, logic push);
    qsp_ctl_t c;
    c.we       = '0;
    c.take_din = '0;
    case (op)
      OP_SHIFT: begin
        c.we              = '1;
        c.take_din[SL_A1] = 1'b1;
      end
      OP_LOAD_A: begin
        c.we[SL_A1]       = 1'b1;
        c.take_din[SL_A1] = 1'b1;
        c.we[SL_A2]       = push;
      end
      OP_LOAD_B: begin
        c.we[SL_B1]       = 1'b1;
        c.take_din[SL_B1] = 1'b1;
        c.we[SL_B2]       = push;
      end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/qsp_decode.sv
`timescale 1ns/1ps
module qsp_decode
  import qsp_pkg::*;
#(
  parameter bit PUSH_DOWN = 1'b1
) (
  input  qsp_op_e  op,
  output qsp_ctl_t ctl,
  output logic     shift_evt,
  output logic     load_a_evt,
  output logic     load_b_evt,
  output logic     hold_evt
);

  always_comb begin
    ctl = decode_op(op, PUSH_DOWN);
  end

  assign shift_evt  = (op == OP_SHIFT);
  assign load_a_evt = (op == OP_LOAD_A);
  assign load_b_evt = (op == OP_LOAD_B);
  assign hold_evt   = (op == OP_HOLD);

endmodule

// File: rtl/qsp_bank.sv
`timescale 1ns/1ps
module qsp_bank
  import qsp_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  qsp_ctl_t                ctl,
  input  logic [W-1:0]            din,
  output logic [SLOTS-1:0][W-1:0] q
);

  logic [SLOTS-1:0][W-1:0] link;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [W-1:0] feed;

    if (k == 0) begin : g_head
      assign link[k] = din;
    end else begin : g_tail
      assign link[k] = q[k-1];
    end

    assign feed = ctl.take_din[k] ? din : link[k];

    always_ff @(posedge clk) begin
      if (rst) begin
        q[k] <= '0;
      end else if (ctl.we[k]) begin
        q[k] <= feed;
      end
    end
  end

endmodule

// File: rtl/qsp_outmux.sv
`timescale 1ns/1ps
module qsp_outmux
  import qsp_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [SLOTS-1:0][W-1:0] q,
  input  logic [SEL_W-1:0]        sel,
  input  logic                    oe_n,
  output logic [W-1:0]            dout,
  output logic                    dout_en
);

  logic [W-1:0] picked;

  assign picked  = q[sel_to_slot(sel)];
  assign dout_en = ~oe_n;
  assign dout    = oe_n ? '0 : picked;

endmodule

// File: rtl/qsp_pipe4.sv
`timescale 1ns/1ps
module qsp_pipe4
  import qsp_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter bit          PUSH_DOWN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic [1:0]        sel_i,
  input  logic              oe_n_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_en_o
);

  qsp_ctl_t                     ctl;
  logic [SLOTS-1:0][DATA_W-1:0] slot_q;
  logic                         shift_evt;
  logic                         load_a_evt;
  logic                         load_b_evt;
  logic                         hold_evt;

  qsp_decode #(.PUSH_DOWN(PUSH_DOWN)) u_dec (
    .op         (qsp_op_e'(op_i)),
    .ctl        (ctl),
    .shift_evt  (shift_evt),
    .load_a_evt (load_a_evt),
    .load_b_evt (load_b_evt),
    .hold_evt   (hold_evt)
  );

  qsp_bank #(.W(DATA_W)) u_bank (
    .clk (clk),
    .rst (rst),
    .ctl (ctl),
    .din (din_i),
    .q   (slot_q)
  );

  qsp_outmux #(.W(DATA_W)) u_mux (
    .q       (slot_q),
    .sel     (SEL_W'(sel_i)),
    .oe_n    (oe_n_i),
    .dout    (dout_o),
    .dout_en (dout_en_o)
  );

endmodule

// File: rtl/qsp_pipe4_chk.sv
`timescale 1ns/1ps
module qsp_pipe4_chk
  import qsp_pkg::*;
#(
  parameter int unsigned W         = 8,
  parameter bit          PUSH_DOWN = 1'b1
) (
  input logic                    clk,
  input logic                    rst,
  input logic [W-1:0]            din,
  input logic [1:0]              sel,
  input logic                    oe_n,
  input logic [W-1:0]            dout,
  input logic                    dout_en,
  input logic [SLOTS-1:0][W-1:0] q,
  input logic                    shift_evt,
  input logic                    load_a_evt,
  input logic                    load_b_evt,
  input logic                    hold_evt
);

  a_r2_one_action: assert property (@(posedge clk) disable iff (rst)
    $onehot({shift_evt, load_a_evt, load_b_evt, hold_evt}));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    hold_evt |=> q == $past(q));

  a_r3_shift: assert property (@(posedge clk) disable iff (rst)
    shift_evt |=> (q[0] == $past(din)) && (q[1] == $past(q[0])) &&
                  (q[2] == $past(q[1])) && (q[3] == $past(q[2])));

  a_r4_load_a: assert property (@(posedge clk) disable iff (rst)
    load_a_evt |=> (q[0] == $past(din)) && (q[2] == $past(q[2])) && (q[3] == $past(q[3])));

  a_r5_load_b: assert property (@(posedge clk) disable iff (rst)
    load_b_evt |=> (q[2] == $past(din)) && (q[0] == $past(q[0])) && (q[1] == $past(q[1])));

  a_r6_push_a: assert property (@(posedge clk) disable iff (rst)
    (PUSH_DOWN && load_a_evt) |=> q[1] == $past(q[0]));

  a_r6_push_b: assert property (@(posedge clk) disable iff (rst)
    (PUSH_DOWN && load_b_evt) |=> q[3] == $past(q[2]));

  a_r7_keep_level2: assert property (@(posedge clk) disable iff (rst)
    (!PUSH_DOWN && (load_a_evt || load_b_evt)) |=> (q[1] == $past(q[1])) && (q[3] == $past(q[3])));

  a_r8_route: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> dout == q[2'd3 - sel]);

  a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (dout == '0) && !dout_en);

  a_r10_drive: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> dout_en);

endmodule

bind qsp_pipe4 qsp_pipe4_chk #(.W(DATA_W), .PUSH_DOWN(PUSH_DOWN)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .din        (din_i),
  .sel        (sel_i),
  .oe_n       (oe_n_i),
  .dout       (dout_o),
  .dout_en    (dout_en_o),
  .q          (slot_q),
  .shift_evt  (shift_evt),
  .load_a_evt (load_a_evt),
  .load_b_evt (load_b_evt),
  .hold_evt   (hold_evt)
);

// File: tb/qsp_pipe4_tb_top.sv
`timescale 1ns/1ps
module qsp_pipe4_tb_top;

  typedef logic [3:0][7:0] img_t; // [0]=A1 [1]=A2 [2]=B1 [3]=B2

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] op  = 2'd3;
  logic [7:0] din = 8'h00;
  logic [1:0] sel = 2'd0;
  logic       oe_n = 1'b0;
  logic [7:0] dout_p, dout_w;
  logic       en_p, en_w;

  int nchk = 0;
  int errs = 0;
  img_t mp = '0; // model, push-down
  img_t mw = '0; // model, overwrite

  always #2 clk = ~clk; // 250 MHz

  qsp_pipe4 #(.DATA_W(8), .PUSH_DOWN(1'b1)) dut_i (
    .clk(clk), .rst(rst), .op_i(op), .din_i(din), .sel_i(sel),
    .oe_n_i(oe_n), .dout_o(dout_p), .dout_en_o(en_p));

  qsp_pipe4 #(.DATA_W(8), .PUSH_DOWN(1'b0)) dut_ow_i (
    .clk(clk), .rst(rst), .op_i(op), .din_i(din), .sel_i(sel),
    .oe_n_i(oe_n), .dout_o(dout_w), .dout_en_o(en_w));

  function automatic img_t nxt(img_t s, logic [1:0] o, logic [7:0] d, bit push);
    img_t r = s;
    case (o)
      2'd0: r = {s[2], s[1], s[0], d};
      2'd1: begin r[2] = d; if (push) r[3] = s[2]; end
      2'd2: begin r[0] = d; if (push) r[1] = s[0]; end
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] pick(img_t s, logic [1:0] sl);
    case (sl)
      2'd0: return s[3];
      2'd1: return s[2];
      2'd2: return s[1];
      default: return s[0];
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // read all four registers of both copies through the select
  task automatic check_all(string why, logic [1:0] last_op);
    oe_n = 1'b0;
    for (int s = 0; s < 4; s++) begin
      string tp, tw;
      sel = 2'(s);
      #0.3;
      tp = why; tw = why;
      if ((last_op == 2'd1 && s == 0) || (last_op == 2'd2 && s == 2)) begin
        tp = "R6 level-2 push";
        tw = "R7 level-2 kept";
      end
      check($sformatf("%s [push sel=%0d] R8", tp, s), dout_p, pick(mp, 2'(s)));
      check($sformatf("%s [ovwr sel=%0d] R8", tw, s), dout_w, pick(mw, 2'(s)));
    end
    check("R10 drive enable push", {7'd0, en_p}, 8'd1);
    check("R10 drive enable ovwr", {7'd0, en_w}, 8'd1);
  endtask

  function automatic string op_tag(logic [1:0] o);
    case (o)
      2'd0: return "R3 shift";
      2'd1: return "R5 load B";
      2'd2: return "R4 load A";
      default: return "R2 hold";
    endcase
  endfunction

  task automatic do_op(logic [1:0] o, logic [7:0] d, logic off);
    mp = nxt(mp, o, d, 1'b1);
    mw = nxt(mw, o, d, 1'b0);
    op = o; din = d; oe_n = off;
    @(posedge clk);
    #0.5;
    op = 2'd3;
    if (off) begin
      check("R9 output zero push", dout_p, 8'h00);
      check("R9 output zero ovwr", dout_w, 8'h00);
      check("R9 enable low push", {7'd0, en_p}, 8'd0);
      check("R9 enable low ovwr", {7'd0, en_w}, 8'd0);
    end
    check_all(off ? {"R9 update while off / ", op_tag(o)} : op_tag(o), o);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    #0.5;
    rst = 1'b0;
    mp = '0; mw = '0;
    check_all("R1 reset clears", 2'd3);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    op = 2'd0; din = 8'hA5; // reset must win over a pending shift
    repeat (2) @(posedge clk);
    #0.5;
    op = 2'd3;
    rst = 1'b0;
    check_all("R1 reset clears", 2'd3);

    // fill the chain with distinct values
    do_op(2'd0, 8'h11, 1'b0);
    do_op(2'd0, 8'h22, 1'b0);
    do_op(2'd0, 8'h33, 1'b0);
    do_op(2'd0, 8'h44, 1'b0);
    do_op(2'd3, 8'hEE, 1'b0);
    do_op(2'd2, 8'h55, 1'b0);
    do_op(2'd1, 8'h66, 1'b0);
    do_op(2'd2, 8'h77, 1'b0);
    do_op(2'd1, 8'h88, 1'b0);
    do_op(2'd0, 8'h99, 1'b0); // old B2 falls off the end
    do_op(2'd2, 8'hAB, 1'b1);
    do_op(2'd0, 8'hCD, 1'b1);
    do_op(2'd3, 8'h01, 1'b1);
    do_reset();

    for (int i = 0; i < 300; i++) begin
      logic [1:0] o;
      logic [7:0] d;
      logic off;
      o   = 2'($urandom_range(0, 3));
      d   = 8'($urandom);
      off = ($urandom_range(0, 3) == 0);
      do_op(o, d, off);
      if (i == 150) do_reset();
    end

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    nchk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

endmodule